// File: doc/BRIEF.md
# Thread Block Admission Controller

This block decides, for one shader core, whether another thread block may be made resident. Three resources are tracked: resident threads, resident block slots and allocated registers. A launch request carries the block's thread count and its registers per thread. The block is granted only if every one of those resources can take it and the resident block count is still under a block cap that software supplies. The cap lets a tuning pass hold concurrency below what the hardware could reach, so that caches and the register file are not oversubscribed.

When a block finishes, a completion notice hands its threads, its registers and its slot back. A request and a completion can arrive in the same cycle. The returned resources then count toward that cycle's decision. A request that could not fit even in an empty core is flagged as an error and is never granted. Live occupancy is also reported, as resident threads over the thread maximum, in whole percent.

Top module: `block_admit`

## Requirements
- R1: After reset, resident threads, resident blocks, allocated registers and occupancy all read 0, and grant and error are low.
- R2: A valid request that fits is granted combinationally in the same cycle. At the next clock edge, resident threads grow by the thread count, resident blocks by one and allocated registers by thread count × registers per thread.
- R3: A request is refused when resident threads plus its thread count would exceed the thread maximum (default 1536).
- R4: A request is refused when allocated registers plus its register need would exceed the register budget (default 32768). Example: 256 threads at 60 registers each fit twice, and a third is refused.
- R5: A request is refused when the hardware block slots (default 8) are all in use.
- R6: A request is refused when resident blocks are not below the block cap input. A cap of 0 refuses everything.
- R7: A completion notice returns its thread count, its registers and one slot at the next clock edge.
- R8: When a completion and a request share a cycle, the completion's resources are freed before the request is judged.
- R9: A valid request whose thread count exceeds the thread maximum, or whose register need exceeds the register budget, raises the error output in that cycle. It is not granted and leaves the state unchanged.
- R10: Occupancy equals floor(resident threads × 100 / thread maximum). It changes at the same edge as the resident thread count, which is one cycle after the admit or release that caused the change.
- R11: With request valid low, grant and error stay low whatever the request fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Launch request present |
| reqThreads | input | 11 | Threads in the requested block |
| reqRegsPerThread | input | 8 | Registers per thread of the requested block |
| relValid | input | 1 | Completion notice present |
| relThreads | input | 11 | Threads of the finishing block |
| relRegsPerThread | input | 8 | Registers per thread of the finishing block |
| blockCap | input | 4 | Software cap on resident blocks |
| grant | output | 1 | Request accepted this cycle |
| tooBig | output | 1 | Request can never fit |
| activeThreads | output | 11 | Resident threads |
| activeBlocks | output | 4 | Resident blocks |
| usedRegs | output | 16 | Allocated registers |
| occupancyPct | output | 7 | Occupancy in whole percent |

## Verification
The bench uses the default parameters: 1536 threads, 8 slots, 32768 registers and 8-bit registers per thread. With these values each limit can be hit on its own. Two 256×60 blocks exhaust registers while threads are still free. Nine 32×1 blocks run out of slots first. Three 512×1 blocks fill the thread limit exactly. An 11-bit thread field can carry a count such as 2000, which exceeds the whole core and so reaches the error path. The cap input is driven down to 2 and to 0 to show software throttling below the slot limit.

// File: rtl/admit_pkg.sv
package admit_pkg;
  // Strobes from the control to the datapath, one per state change.
  typedef struct packed {
    logic doAdmit;
    logic doRelease;
  } admitStrobe_t;
endpackage

// File: rtl/admit_ctrl.sv
module admit_ctrl
  import admit_pkg::*;
(
  input  logic         reqValid,
  input  logic         relValid,
  input  logic         fitThreads,
  input  logic         fitRegs,
  input  logic         fitSlots,
  input  logic         fitCap,
  input  logic         oversize,
  output admitStrobe_t strobe,
  output logic         grant,
  output logic         tooBig
);
  logic allFit;

  always_comb begin
    allFit           = fitThreads & fitRegs & fitSlots & fitCap;
    tooBig           = reqValid & oversize;
    grant            = reqValid & ~oversize & allFit;
    strobe.doAdmit   = grant;
    strobe.doRelease = relValid;
  end
endmodule

// File: rtl/admit_dp.sv
module admit_dp
  import admit_pkg::*;
#(
  parameter int MAX_THREADS = 1536,
  parameter int MAX_BLOCKS  = 8,
  parameter int MAX_REGS    = 32768,
  parameter int RPT_W       = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  admitStrobe_t                     strobe,
  input  logic                             relValid,
  input  logic [$clog2(MAX_THREADS+1)-1:0] reqThreads,
  input  logic [RPT_W-1:0]                 reqRpt,
  input  logic [$clog2(MAX_THREADS+1)-1:0] relThreads,
  input  logic [RPT_W-1:0]                 relRpt,
  input  logic [$clog2(MAX_BLOCKS+1)-1:0]  blockCap,
  output logic                             fitThreads,
  output logic                             fitRegs,
  output logic                             fitSlots,
  output logic                             fitCap,
  output logic                             oversize,
  output logic [$clog2(MAX_THREADS+1)-1:0] activeThreads,
  output logic [$clog2(MAX_BLOCKS+1)-1:0]  activeBlocks,
  output logic [$clog2(MAX_REGS+1)-1:0]    usedRegs,
  output logic [6:0]                       occupancyPct
);
  localparam int TCW = $clog2(MAX_THREADS + 1);
  localparam int BCW = $clog2(MAX_BLOCKS + 1);
  localparam int RCW = $clog2(MAX_REGS + 1);
  localparam int PW  = TCW + RPT_W;
  localparam int SW  = ((PW > RCW) ? PW : RCW) + 1;
  localparam int OW  = TCW + 8;

  logic [TCW-1:0] thrQ;
  logic [BCW-1:0] blkQ;
  logic [RCW-1:0] regQ;
  logic [6:0]     occQ;

  logic [SW-1:0]  reqRegs, relRegs;
  logic [SW-1:0]  afterThr, afterReg;
  logic [BCW-1:0] afterBlk;
  logic [SW-1:0]  nextThr, nextReg;
  logic [BCW-1:0] nextBlk;
  logic [OW-1:0]  scaled;

  // Freed resources are taken off first, so a same-cycle request sees them.
  always_comb begin
    reqRegs  = SW'(reqThreads) * SW'(reqRpt);
    relRegs  = SW'(relThreads) * SW'(relRpt);
    afterThr = SW'(thrQ) - (relValid ? SW'(relThreads) : '0);
    afterReg = SW'(regQ) - (relValid ? relRegs : '0);
    afterBlk = blkQ - (relValid ? BCW'(1) : '0);

    oversize   = (SW'(reqThreads) > SW'(MAX_THREADS)) || (reqRegs > SW'(MAX_REGS));
    fitThreads = (afterThr + SW'(reqThreads)) <= SW'(MAX_THREADS);
    fitRegs    = (afterReg + reqRegs) <= SW'(MAX_REGS);
    fitSlots   = afterBlk < BCW'(MAX_BLOCKS);
    fitCap     = afterBlk < blockCap;
  end

  // Next state after the strobes are applied.
  always_comb begin
    nextThr = (strobe.doRelease ? afterThr : SW'(thrQ))
            + (strobe.doAdmit ? SW'(reqThreads) : '0);
    nextReg = (strobe.doRelease ? afterReg : SW'(regQ))
            + (strobe.doAdmit ? reqRegs : '0);
    nextBlk = (strobe.doRelease ? afterBlk : blkQ)
            + (strobe.doAdmit ? BCW'(1) : '0);
    scaled  = OW'(TCW'(nextThr)) * OW'(100);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      thrQ <= '0;
      blkQ <= '0;
      regQ <= '0;
      occQ <= '0;
    end else begin
      thrQ <= TCW'(nextThr);
      blkQ <= nextBlk;
      regQ <= RCW'(nextReg);
      occQ <= 7'(scaled / OW'(MAX_THREADS));
    end
  end

  assign activeThreads = thrQ;
  assign activeBlocks  = blkQ;
  assign usedRegs      = regQ;
  assign occupancyPct  = occQ;
endmodule

// File: rtl/block_admit.sv
module block_admit
  import admit_pkg::*;
#(
  parameter int MAX_THREADS = 1536,
  parameter int MAX_BLOCKS  = 8,
  parameter int MAX_REGS    = 32768,
  parameter int RPT_W       = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             reqValid,
  input  logic [$clog2(MAX_THREADS+1)-1:0] reqThreads,
  input  logic [RPT_W-1:0]                 reqRegsPerThread,
  input  logic                             relValid,
  input  logic [$clog2(MAX_THREADS+1)-1:0] relThreads,
  input  logic [RPT_W-1:0]                 relRegsPerThread,
  input  logic [$clog2(MAX_BLOCKS+1)-1:0]  blockCap,
  output logic                             grant,
  output logic                             tooBig,
  output logic [$clog2(MAX_THREADS+1)-1:0] activeThreads,
  output logic [$clog2(MAX_BLOCKS+1)-1:0]  activeBlocks,
  output logic [$clog2(MAX_REGS+1)-1:0]    usedRegs,
  output logic [6:0]                       occupancyPct
);
  admitStrobe_t strobe;
  logic fitThreads, fitRegs, fitSlots, fitCap, oversize;

  admit_ctrl u_ctrl (
    .reqValid  (reqValid),
    .relValid  (relValid),
    .fitThreads(fitThreads),
    .fitRegs   (fitRegs),
    .fitSlots  (fitSlots),
    .fitCap    (fitCap),
    .oversize  (oversize),
    .strobe    (strobe),
    .grant     (grant),
    .tooBig    (tooBig)
  );

  admit_dp #(
    .MAX_THREADS(MAX_THREADS),
    .MAX_BLOCKS (MAX_BLOCKS),
    .MAX_REGS   (MAX_REGS),
    .RPT_W      (RPT_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .relValid     (relValid),
    .reqThreads   (reqThreads),
    .reqRpt       (reqRegsPerThread),
    .relThreads   (relThreads),
    .relRpt       (relRegsPerThread),
    .blockCap     (blockCap),
    .fitThreads   (fitThreads),
    .fitRegs      (fitRegs),
    .fitSlots     (fitSlots),
    .fitCap       (fitCap),
    .oversize     (oversize),
    .activeThreads(activeThreads),
    .activeBlocks (activeBlocks),
    .usedRegs     (usedRegs),
    .occupancyPct (occupancyPct)
  );
endmodule

// File: rtl/block_admit_chk.sv
module block_admit_chk #(
  parameter int MAX_THREADS = 1536,
  parameter int MAX_BLOCKS  = 8,
  parameter int MAX_REGS    = 32768,
  parameter int RPT_W       = 8
) (
  input logic                             clk,
  input logic                             rstN,
  input logic                             reqValid,
  input logic                             relValid,
  input logic [$clog2(MAX_BLOCKS+1)-1:0]  blockCap,
  input logic                             grant,
  input logic                             tooBig,
  input logic [$clog2(MAX_THREADS+1)-1:0] activeThreads,
  input logic [$clog2(MAX_BLOCKS+1)-1:0]  activeBlocks,
  input logic [$clog2(MAX_REGS+1)-1:0]    usedRegs
);
  localparam int BCW = $clog2(MAX_BLOCKS + 1);

  p_grant_needs_req_r11: assert property (@(posedge clk) disable iff (!rstN)
    (grant || tooBig) |-> reqValid);

  p_admit_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (grant && !relValid) |=> activeBlocks == $past(activeBlocks) + BCW'(1));

  p_thread_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    32'(activeThreads) <= MAX_THREADS);

  p_reg_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    32'(usedRegs) <= MAX_REGS);

  p_slot_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    32'(activeBlocks) <= MAX_BLOCKS);

  p_cap_respected_r6: assert property (@(posedge clk) disable iff (!rstN)
    (grant && !relValid) |-> activeBlocks < blockCap);

  p_release_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (relValid && !grant) |=> activeBlocks == $past(activeBlocks) - BCW'(1));

  p_no_grant_oversize_r9: assert property (@(posedge clk) disable iff (!rstN)
    tooBig |-> !grant);

  p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!grant && !relValid) |=> $stable(activeThreads) && $stable(usedRegs));
endmodule

bind block_admit block_admit_chk #(
  .MAX_THREADS(MAX_THREADS),
  .MAX_BLOCKS (MAX_BLOCKS),
  .MAX_REGS   (MAX_REGS),
  .RPT_W      (RPT_W)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .reqValid     (reqValid),
  .relValid     (relValid),
  .blockCap     (blockCap),
  .grant        (grant),
  .tooBig       (tooBig),
  .activeThreads(activeThreads),
  .activeBlocks (activeBlocks),
  .usedRegs     (usedRegs)
);

// File: tb/block_admit_bench.sv
module block_admit_bench;
  localparam int MT = 1536;
  localparam int MB = 8;
  localparam int MR = 32768;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [10:0] reqThreads = '0;
  logic [7:0]  reqRegsPerThread = '0;
  logic        relValid = 1'b0;
  logic [10:0] relThreads = '0;
  logic [7:0]  relRegsPerThread = '0;
  logic [3:0]  blockCap = 4'd8;
  logic        grant, tooBig;
  logic [10:0] activeThreads;
  logic [3:0]  activeBlocks;
  logic [15:0] usedRegs;
  logic [6:0]  occupancyPct;

  block_admit u_block_admit (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqThreads(reqThreads), .reqRegsPerThread(reqRegsPerThread),
    .relValid(relValid), .relThreads(relThreads), .relRegsPerThread(relRegsPerThread),
    .blockCap(blockCap), .grant(grant), .tooBig(tooBig),
    .activeThreads(activeThreads), .activeBlocks(activeBlocks),
    .usedRegs(usedRegs), .occupancyPct(occupancyPct)
  );

  always #4 clk = ~clk;

  typedef struct {
    bit    g;
    bit    e;
    int    thr;
    int    blk;
    int    regs;
    int    occ;
    string tag;
  } item_t;

  item_t q[$];
  int nChecks = 0;
  int nFail = 0;
  int mThr = 0, mBlk = 0, mReg = 0;
  int capV = 8;
  bit done = 1'b0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Driver: drives one cycle and queues what the outputs must show.
  task automatic cyc(input bit rv, input int t, input int r,
                     input bit lv, input int lt, input int lr, input string tag);
    item_t it;
    int aT, aB, aR;
    bit big, g, e;
    @(negedge clk);
    reqValid = rv; reqThreads = 11'(t); reqRegsPerThread = 8'(r);
    relValid = lv; relThreads = 11'(lt); relRegsPerThread = 8'(lr);
    blockCap = 4'(capV);
    aT = mThr - (lv ? lt : 0);
    aB = mBlk - (lv ? 1 : 0);
    aR = mReg - (lv ? lt * lr : 0);
    big = (t > MT) || (t * r > MR);
    g = rv && !big && (aT + t <= MT) && (aR + t * r <= MR) && (aB < MB) && (aB < capV);
    e = rv && big;
    it.g = g; it.e = e; it.thr = mThr; it.blk = mBlk; it.regs = mReg;
    it.occ = mThr * 100 / MT; it.tag = tag;
    q.push_back(it);
    mThr = aT + (g ? t : 0);
    mBlk = aB + (g ? 1 : 0);
    mReg = aR + (g ? t * r : 0);
  endtask

  task automatic idle(input string tag);
    cyc(1'b0, 2047, 255, 1'b0, 0, 0, tag);
  endtask

  // Monitor: pops expectations and compares them mid-cycle.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        chk(it.tag, "grant", int'(grant), int'(it.g));
        chk(it.tag, "tooBig", int'(tooBig), int'(it.e));
        chk(it.tag, "activeThreads", int'(activeThreads), it.thr);
        chk(it.tag, "activeBlocks", int'(activeBlocks), it.blk);
        chk(it.tag, "usedRegs", int'(usedRegs), it.regs);
        chk("R10", "occupancyPct", int'(occupancyPct), it.occ);
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    #2;
    chk("R1", "reset activeThreads", int'(activeThreads), 0);
    chk("R1", "reset activeBlocks", int'(activeBlocks), 0);
    chk("R1", "reset usedRegs", int'(usedRegs), 0);
    chk("R1", "reset occupancy", int'(occupancyPct), 0);
    chk("R1", "reset grant", int'(grant), 0);

    idle("R11");
    cyc(1, 256, 60, 0, 0, 0, "R2");
    cyc(1, 256, 60, 0, 0, 0, "R4");
    cyc(1, 256, 60, 0, 0, 0, "R4");
    idle("R10");
    cyc(0, 0, 0, 1, 256, 60, "R7");
    cyc(0, 0, 0, 1, 256, 60, "R7");
    idle("R7");

    cyc(1, 2000, 1, 0, 0, 0, "R9");
    cyc(1, 512, 70, 0, 0, 0, "R9");
    idle("R9");

    for (int i = 0; i < 9; i++) cyc(1, 32, 1, 0, 0, 0, "R5");
    cyc(1, 32, 1, 1, 32, 1, "R8");
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 1, 32, 1, "R7");
    idle("R7");

    for (int i = 0; i < 4; i++) cyc(1, 512, 1, 0, 0, 0, "R3");
    cyc(1, 512, 1, 1, 512, 1, "R8");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 512, 1, "R7");
    idle("R11");

    capV = 2;
    for (int i = 0; i < 3; i++) cyc(1, 64, 2, 0, 0, 0, "R6");
    cyc(0, 0, 0, 1, 64, 2, "R6");
    cyc(0, 0, 0, 1, 64, 2, "R6");
    capV = 0;
    cyc(1, 32, 1, 0, 0, 0, "R6");
    idle("R6");
    capV = 8;
    idle("R11");

    @(negedge clk);
    reqValid = 1'b0; relValid = 1'b0;
    repeat (2) @(negedge clk);
    #3;
    chk("R1", "queue drained", q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule